// File: doc/BRIEF.md
# Recirculating Delay-Loop Binary Counter

This block is an up counter of parameterised width in which no bit is built from a toggle flip-flop or a carry chain. Bit k of the count is the tail of its own closed delay line that is 2^k stages long. The tail is inverted and passed through a three-input majority gate, with one input tied low, so the gate acts as an AND with the shared reset. The result is fed back into the head of the line. Each trip around a loop therefore flips the stored value, and each bit flips half as often as the bit below it. Together the bits form a binary count.

A single active-low reset clears every loop: while it is low, zeros are shifted into every head. Once the deepest loop has been fully flushed, releasing the reset starts the count. A valid flag reports when the whole count can be trusted. That is one full period of the deepest loop after release, and only if the preceding reset lasted long enough to flush that loop.

Top module: `loop_counter`

## Requirements
- R1: Once counting, bit k of `count` changes state every 2^k clock cycles: bit 0 on every cycle and the top bit (bit 3 at the default N=4) every 8 cycles.
- R2: After `rst_n` has been sampled low on at least 2^(N-1) consecutive rising edges (8 at N=4), `count` reads all zeros.
- R3: After a full-length reset, the value of `count` following the n-th rising edge with `rst_n` high equals n modulo 2^N.
- R4: At the default width, `count` wraps from 15 back to 0 on the 16th, 32nd, and so on, rising edge after release.
- R5: `valid` rises after the 2^(N-1)-th rising edge following release, when `count` reads 8 at N=4. It then stays high for as long as `rst_n` stays high.
- R6: `valid` is low in any cycle in which `rst_n` is low. This holds combinationally and needs no clock edge.
- R7: If the preceding reset lasted fewer than 2^(N-1) rising edges, `valid` stays low throughout the following run, until a full-length reset occurs.
- R8: A full-length reset applied in the middle of a count restarts the sequence, so that the first edge after the new release gives 1 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all loops and the settle tracker |
| rst_n | input | 1 | Shared active-low reset, sampled synchronously; gates each loop head |
| count | output | N | Count value; bit k is the tail of the 2^k-stage loop |
| valid | output | 1 | High when `count` holds a trustworthy value |

## Verification
The bench runs well past two wraps of the counter, so a loop with the wrong depth or an inverted feedback would break the n-mod-16 sequence at the first toggle of its bit. It checks that the count reads zero after a full reset and that the count restarts after a reset in mid-run; a head that ignored the reset gate would keep counting from its old value. A deliberately short reset must leave `valid` low for the whole following run; a tracker that ignored the flush length would raise it on stale loop contents. The rise of `valid` is checked on the exact cycle it should occur, so an off-by-one settle counter shows up on the edge before or after.

// File: rtl/loop_counter_pkg.sv
// Package: loop_counter_pkg
// Shared helpers for the delay-loop counter: the three-input majority
// function used as the gating element and the loop-depth rule.
// Assumes callers pass a bit index below 31.
package loop_counter_pkg;

    // Three-input majority: true when at least two inputs are true.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // Number of stages in the loop that drives bit k.
    function automatic int unsigned loop_depth(input int unsigned k);
        return 32'd1 << k;
    endfunction

endpackage

// File: rtl/lc_delay_loop.sv
// Module: lc_delay_loop
// One closed delay line of DEPTH stages. The head is loaded with the
// inverted tail, gated by the reset through a majority gate with one input
// tied low (an AND). The tail is the output bit, which inverts once per
// trip around the loop. Assumes DEPTH >= 1 and that reset is held for at
// least DEPTH cycles before the tail is trusted.
module lc_delay_loop #(
    parameter int unsigned DEPTH = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tap
);
    import loop_counter_pkg::*;

    logic [DEPTH-1:0] stage;
    logic             head;

    // Feedback: invert the tail, then AND it with reset through the majority gate.
    always_comb begin
        head = maj3(~stage[DEPTH-1], rst_n, 1'b0);
    end

    generate
        if (DEPTH == 1) begin : g_single
            // Single stage: the head value lands directly in the tail.
            always_ff @(posedge clk) begin
                stage[0] <= head;
            end
        end else begin : g_chain
            // Multi-stage: shift the head value toward the tail by one stage.
            always_ff @(posedge clk) begin
                stage <= {stage[DEPTH-2:0], head};
            end
        end
    endgenerate

    // Output tap: the tail of the line.
    assign tap = stage[DEPTH-1];

endmodule

// File: rtl/lc_settle_tracker.sv
// Module: lc_settle_tracker
// Decides when the combined count can be trusted. A flush chain of LAT
// stages fills with ones only after LAT consecutive low reset samples,
// whatever it held before. At the first edge after release, that chain
// says whether the deepest loop was fully cleared. A run counter then
// waits LAT edges before the flag is raised. The flag is also gated
// combinationally by reset. Assumes LAT >= 1.
module lc_settle_tracker #(
    parameter int unsigned LAT = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic valid
);
    localparam int unsigned CW = $clog2(LAT + 1);
    localparam logic [CW-1:0] RUN_DONE = CW'(LAT);

    logic [LAT-1:0] flush_sr;
    logic           started;
    logic           armed;
    logic [CW-1:0]  run_cnt;

    generate
        if (LAT == 1) begin : g_flush1
            // Flush chain of one stage: set by any low reset sample.
            always_ff @(posedge clk) begin
                flush_sr[0] <= ~rst_n;
            end
        end else begin : g_flushn
            // Flush chain: a one walks in per low sample; any high sample clears it.
            always_ff @(posedge clk) begin
                flush_sr <= {flush_sr[LAT-2:0], 1'b1} & {LAT{~rst_n}};
            end
        end
    endgenerate

    // Run state: latch the flush result at release, then count up to LAT edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started <= 1'b0;
            armed   <= 1'b0;
            run_cnt <= '0;
        end else begin
            started <= 1'b1;
            if (!started) begin
                armed <= flush_sr[LAT-1];
            end
            if (run_cnt != RUN_DONE) begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    // Valid flag: armed, settled, and not currently held in reset.
    always_comb begin
        valid = rst_n & armed & (run_cnt == RUN_DONE);
    end

endmodule

// File: rtl/loop_counter.sv
// Module: loop_counter
// N-bit up counter built from N independent recirculating delay loops.
// Loop k holds 2^k stages, so its tail flips every 2^k cycles and the
// tails together read as a binary count. One shared active-low reset
// gates every loop head. A settle tracker raises valid one deepest-loop
// period after release. Assumes N between 1 and 10 and that reset is held
// for at least 2^(N-1) cycles before counting is wanted.
module loop_counter #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [N-1:0] count,
    output logic         valid
);
    import loop_counter_pkg::*;

    localparam int unsigned LAT = loop_depth(N - 1);

    // One delay loop per output bit; the depth doubles with each bit.
    generate
        for (genvar k = 0; k < N; k++) begin : g_bit
            lc_delay_loop #(
                .DEPTH(loop_depth(k))
            ) u_loop (
                .clk  (clk),
                .rst_n(rst_n),
                .tap  (count[k])
            );
        end
    endgenerate

    // Trust tracker shared by all bits.
    lc_settle_tracker #(
        .LAT(LAT)
    ) u_settle (
        .clk  (clk),
        .rst_n(rst_n),
        .valid(valid)
    );

endmodule

// File: rtl/loop_counter_chk.sv
// Module: loop_counter_chk
// Temporal checks on the counter ports, attached to every loop_counter
// through the bind below. Assumes reset is low at time zero.
module loop_counter_chk #(
    parameter int unsigned N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] count,
    input logic         valid
);
    localparam int unsigned LAT = 32'd1 << (N - 1);

    // R6
    valid_low_in_reset_chk: assert property (@(posedge clk)
        !rst_n |-> !valid);

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && $past(valid)) |-> (count == N'($past(count) + 1'b1)));

    // R5
    valid_rise_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> (count == N'(LAT)));

    // R5
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> valid);

    // R1
    lsb_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n)) |-> (count[0] != $past(count[0])));

endmodule

bind loop_counter loop_counter_chk #(.N(N)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .count(count),
    .valid(valid)
);

// File: tb/loop_counter_tb.sv
// Bench for loop_counter: a driver task models the expected outputs and
// pushes them into queues, and a monitor pops and compares them after each edge.
module loop_counter_tb;
    localparam int N   = 4;
    localparam int MOD = 1 << N;
    localparam int LAT = 1 << (N - 1);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] count;
    logic         valid;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    int    q_cnt[$];
    bit    q_chk[$];
    bit    q_vld[$];
    string q_ctag[$];
    string q_vtag[$];

    int low_run = 0;
    int n_since = 0;
    bit armed_m = 1'b0;

    loop_counter #(.N(N)) u_dut (
        .clk  (clk),
        .rst_n(rst_n),
        .count(count),
        .valid(valid)
    );

    always #10 clk = ~clk;

    // Driver: drive reset at the falling edge and push the result expected after the next rise.
    task automatic step(input bit r, input string scen);
        int ec;
        @(negedge clk);
        rst_n = r;
        if (!r) begin
            low_run++;
            n_since = 0;
            q_cnt.push_back(0);
            q_chk.push_back(low_run >= LAT);
            q_vld.push_back(1'b0);
            q_ctag.push_back("R2");
            q_vtag.push_back("R6");
        end else begin
            if (n_since == 0) armed_m = (low_run >= LAT);
            low_run = 0;
            n_since++;
            ec = n_since % MOD;
            q_cnt.push_back(ec);
            q_chk.push_back(armed_m);
            q_vld.push_back(armed_m && (n_since >= LAT));
            q_ctag.push_back(ec == 0 ? "R4" : scen);
            q_vtag.push_back(armed_m ? "R5" : "R7");
        end
    endtask

    task automatic run(input bit r, input int cycles, input string scen);
        for (int i = 0; i < cycles; i++) step(r, scen);
    endtask

    // Monitor: compare the outputs a quarter period after each rising edge.
    always @(posedge clk) begin
        #5;
        if (q_cnt.size() > 0) begin
            int    ec;
            bit    ck;
            bit    ev;
            string ct;
            string vt;
            ec = q_cnt.pop_front();
            ck = q_chk.pop_front();
            ev = q_vld.pop_front();
            ct = q_ctag.pop_front();
            vt = q_vtag.pop_front();
            if (ck) begin
                n_checks++;
                if (count !== N'(ec)) begin
                    n_fail++;
                    $display("FAIL %s count: actual %0d expected %0d", ct, count, ec);
                end
            end
            n_checks++;
            if (valid !== ev) begin
                n_fail++;
                $display("FAIL %s valid: actual %0b expected %0b", vt, valid, ev);
            end
        end
    end

    // Watchdog: a hung run counts as one failure and still prints the summary.
    initial begin
        #(20 * 5000);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        run(1'b0, 10, "R2");          // full reset: count zero (R2), valid low (R6)
        run(1'b1, 40, "R1,R3");       // count 1..40 mod 16, wraps twice (R4), valid at 8 (R5)
        run(1'b0, 3,  "R2");          // short reset: valid low (R6)
        run(1'b1, 12, "R7");          // run after short reset: valid must stay low (R7)
        run(1'b0, 9,  "R2");          // full reset again
        run(1'b1, 20, "R8");          // restart from 1 after the mid-run reset (R8)
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule